// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one of several PLLs without ever exposing downstream logic to a PLL that is unlocked or being reprogrammed. A request selects a PLL and gives raw values for the input divider (NR), the feedback multiplier (NF) and the output divider (NO). The request is first checked against the VCO and output frequency limits. If it is legal, the sequencer steps through a fixed chain of one-cycle stages:

1. Switch that PLL's consumers to the reference clock.
2. Hold the PLL in reset.
3. Write the divider fields, each stored as value minus one.
4. Optionally write a loop bandwidth adjust field.
5. Release reset and wait for lock.
6. Switch the consumers back to the PLL output.

The analog PLL lies outside the block. Its lock indication arrives on one input bit per PLL. A separate rate port reports, in whole MHz, the clock that the consumers of a chosen PLL currently see. The reference clock is 24 MHz.

Top module: `pll_reprog_ctrl`

## Requirements
- R1: After reset every PLL is in slow mode (`mode_o` bit 0 = slow, 1 = normal) and out of reset. All divider and bandwidth fields are zero, `busy_o` and both error flags are low, and the rate port reports 24 for every PLL.
- R2: A legal request is accepted on the clock edge where `req_valid_i` is high while idle, and `busy_o` rises on that edge. The following edges then act in order, one per edge:
  - first edge: the selected PLL's mode bit falls;
  - second edge: its reset bit rises;
  - third edge: its divider fields change;
  - fourth edge: the bandwidth stage;
  - fifth edge: its reset bit falls.

  A PLL is never in reset while its mode bit is normal, and at most one PLL is in reset at a time.
- R3: The divider fields hold NR−1, NF−1 and NO−1, and they change only while that PLL is in reset.
- R4: When `bwadj_en_i` is high, the bandwidth field of the selected PLL is written with NF/2−1 (integer division).
- R5: When `bwadj_en_i` is low, the bandwidth field keeps its previous value.
- R6: After reset is released, the mode bit returns to normal only on the edge after the selected PLL's `lock_i` bit is seen high. `busy_o` falls on that same edge.
- R7: A request is legal only when all of the following hold:
  - NR, NF and NO are nonzero;
  - 440 ≤ 24·NF/NR ≤ 2200;
  - 30 ≤ 24·NF/(NR·NO) ≤ 2200;
  - NO is 1 or even.

  An illegal request sets `err_illegal_o` and leaves all mode, reset and field outputs unchanged. `busy_o` stays low.
- R8: If lock is not seen within `timeout_i`+1 wait cycles, `err_timeout_o` rises and `busy_o` falls. The PLL stays in slow mode, out of reset. Both error flags are cleared by the next request seen while idle.
- R9: Requests that arrive while `busy_o` is high are ignored. They change no mode bit, reset bit or field of any PLL.
- R10: In normal mode the rate port reports 24·NF/(NR·NO) in integer MHz, using the decoded (plus one) fields of the PLL chosen by `rate_sel_i`. In slow mode it reports 24.
- R11: A sequence touches only the selected PLL. The mode bits, reset bits and fields of all other PLLs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bwadj_en_i | input | 1 | Chip variant has a bandwidth adjust field |
| timeout_i | input | TO_W | Lock wait limit in cycles |
| req_valid_i | input | 1 | Request strobe |
| req_pll_i | input | SEL_W | PLL index of the request |
| req_nr_i | input | NR_W | Input divider, raw value |
| req_nf_i | input | NF_W | Feedback multiplier, raw value |
| req_no_i | input | NO_W | Output divider, raw value |
| lock_i | input | NPLL | Lock flag per PLL |
| rate_sel_i | input | SEL_W | PLL whose rate is reported |
| busy_o | output | 1 | Sequence in progress |
| err_illegal_o | output | 1 | Last request rejected |
| err_timeout_o | output | 1 | Last sequence timed out waiting for lock |
| mode_o | output | NPLL | 1 = consumers on PLL output, 0 = on reference |
| pll_rst_o | output | NPLL | PLL reset per PLL |
| cfg_nr_o | output | NPLL*NR_W | NR−1 per PLL |
| cfg_no_o | output | NPLL*NO_W | NO−1 per PLL |
| cfg_nf_o | output | NPLL*NF_W | NF−1 per PLL |
| cfg_bw_o | output | NPLL*BW_W | Bandwidth adjust per PLL |
| rate_mhz_o | output | RATE_W | Current consumer clock of the selected PLL, in MHz |

## Verification
The hardest condition to reach is a lock that never arrives. The bench therefore models lock per PLL: a lock bit rises a few cycles after that PLL leaves reset, and the bench can block it. With the lock blocked and a short timeout, the timeout path runs and leaves the PLL in slow mode. A later request with the lock unblocked shows that the error flag clears.

The ordering check starts from a PLL that is already in normal mode, so that each of the mode, reset and field transitions can be seen at its own negative edge. The ignored-request case injects a second request two cycles into a running sequence.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOW,
    ST_RST,
    ST_PROG,
    ST_BW,
    ST_REL,
    ST_WAIT,
    ST_NORM
  } seq_st_e;
endpackage

// File: rtl/pll_legal_chk.sv
module pll_legal_chk #(
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int REF_MHZ     = 24,
  parameter int VCO_MIN_MHZ = 440,
  parameter int VCO_MAX_MHZ = 2200,
  parameter int OUT_MIN_MHZ = 30,
  parameter int OUT_MAX_MHZ = 2200
) (
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  output logic            legal_o
);
  logic [31:0] vco_x, rr, rd;
  logic        nz, vco_ok, out_ok, no_ok;

  // compare by cross-multiplying, no divider in the check path
  always_comb begin
    vco_x  = 32'(REF_MHZ) * 32'(nf_i);
    rr     = 32'(nr_i);
    rd     = 32'(nr_i) * 32'(no_i);
    nz     = (nr_i != '0) && (nf_i != '0) && (no_i != '0);
    vco_ok = (vco_x >= 32'(VCO_MIN_MHZ) * rr) && (vco_x <= 32'(VCO_MAX_MHZ) * rr);
    out_ok = (vco_x >= 32'(OUT_MIN_MHZ) * rd) && (vco_x <= 32'(OUT_MAX_MHZ) * rd);
    no_ok  = (no_i == NO_W'(1)) || !no_i[0];
    legal_o = nz && vco_ok && out_ok && no_ok;
  end
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank #(
  parameter int NPLL  = 4,
  parameter int NR_W  = 6,
  parameter int NF_W  = 13,
  parameter int NO_W  = 4,
  parameter int BW_W  = 12,
  parameter int SEL_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 mode_clr_i,
  input  logic                 mode_set_i,
  input  logic                 rst_set_i,
  input  logic                 rst_clr_i,
  input  logic                 prog_i,
  input  logic                 bw_wr_i,
  input  logic [NR_W-1:0]      nr_m1_i,
  input  logic [NF_W-1:0]      nf_m1_i,
  input  logic [NO_W-1:0]      no_m1_i,
  input  logic [BW_W-1:0]      bw_i,
  output logic [NPLL-1:0]      mode_o,
  output logic [NPLL-1:0]      rst_o,
  output logic [NPLL*NR_W-1:0] nr_o,
  output logic [NPLL*NF_W-1:0] nf_o,
  output logic [NPLL*NO_W-1:0] no_o,
  output logic [NPLL*BW_W-1:0] bw_o
);
  for (genvar g = 0; g < NPLL; g++) begin : g_pll
    logic hit;
    logic            mode_q, rst_q;
    logic [NR_W-1:0] nr_q;
    logic [NF_W-1:0] nf_q;
    logic [NO_W-1:0] no_q;
    logic [BW_W-1:0] bw_q;

    assign hit = (sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q <= 1'b0;
        rst_q  <= 1'b0;
        nr_q   <= '0;
        nf_q   <= '0;
        no_q   <= '0;
        bw_q   <= '0;
      end else if (hit) begin
        if (mode_clr_i) mode_q <= 1'b0;
        if (mode_set_i) mode_q <= 1'b1;
        if (rst_set_i)  rst_q  <= 1'b1;
        if (rst_clr_i)  rst_q  <= 1'b0;
        if (prog_i) begin
          nr_q <= nr_m1_i;
          nf_q <= nf_m1_i;
          no_q <= no_m1_i;
        end
        if (bw_wr_i) bw_q <= bw_i;
      end
    end

    assign mode_o[g]              = mode_q;
    assign rst_o[g]               = rst_q;
    assign nr_o[g*NR_W +: NR_W]   = nr_q;
    assign nf_o[g*NF_W +: NF_W]   = nf_q;
    assign no_o[g*NO_W +: NO_W]   = no_q;
    assign bw_o[g*BW_W +: BW_W]   = bw_q;
  end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int NO_W    = 4,
  parameter int REF_MHZ = 24,
  parameter int RATE_W  = 19
) (
  input  logic              mode_i,
  input  logic [NR_W-1:0]   nr_m1_i,
  input  logic [NF_W-1:0]   nf_m1_i,
  input  logic [NO_W-1:0]   no_m1_i,
  output logic [RATE_W-1:0] rate_o
);
  logic [31:0] num, den, quo;

  always_comb begin
    num = 32'(REF_MHZ) * (32'(nf_m1_i) + 32'd1);
    den = (32'(nr_m1_i) + 32'd1) * (32'(no_m1_i) + 32'd1);
    quo = num / den;
    rate_o = mode_i ? RATE_W'(quo) : RATE_W'(REF_MHZ);
  end
endmodule

// File: rtl/pll_reprog_ctrl.sv
module pll_reprog_ctrl
  import pll_seq_pkg::*;
#(
  parameter int NPLL        = 4,
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int BW_W        = 12,
  parameter int TO_W        = 16,
  parameter int REF_MHZ     = 24,
  parameter int VCO_MIN_MHZ = 440,
  parameter int VCO_MAX_MHZ = 2200,
  parameter int OUT_MIN_MHZ = 30,
  parameter int OUT_MAX_MHZ = 2200,
  localparam int SEL_W      = (NPLL > 1) ? $clog2(NPLL) : 1,
  localparam int RATE_W     = NF_W + 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bwadj_en_i,
  input  logic [TO_W-1:0]      timeout_i,
  input  logic                 req_valid_i,
  input  logic [SEL_W-1:0]     req_pll_i,
  input  logic [NR_W-1:0]      req_nr_i,
  input  logic [NF_W-1:0]      req_nf_i,
  input  logic [NO_W-1:0]      req_no_i,
  input  logic [NPLL-1:0]      lock_i,
  input  logic [SEL_W-1:0]     rate_sel_i,
  output logic                 busy_o,
  output logic                 err_illegal_o,
  output logic                 err_timeout_o,
  output logic [NPLL-1:0]      mode_o,
  output logic [NPLL-1:0]      pll_rst_o,
  output logic [NPLL*NR_W-1:0] cfg_nr_o,
  output logic [NPLL*NO_W-1:0] cfg_no_o,
  output logic [NPLL*NF_W-1:0] cfg_nf_o,
  output logic [NPLL*BW_W-1:0] cfg_bw_o,
  output logic [RATE_W-1:0]    rate_mhz_o
);
  seq_st_e          st_q;
  logic [SEL_W-1:0] sel_q;
  logic [NR_W-1:0]  nr_q;
  logic [NF_W-1:0]  nf_q;
  logic [NO_W-1:0]  no_q;
  logic [TO_W-1:0]  cnt_q;
  logic             busy_q, err_ill_q, err_to_q;
  logic             legal;

  pll_legal_chk #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_MHZ(REF_MHZ),
    .VCO_MIN_MHZ(VCO_MIN_MHZ), .VCO_MAX_MHZ(VCO_MAX_MHZ),
    .OUT_MIN_MHZ(OUT_MIN_MHZ), .OUT_MAX_MHZ(OUT_MAX_MHZ)
  ) u_legal (
    .nr_i    (req_nr_i),
    .nf_i    (req_nf_i),
    .no_i    (req_no_i),
    .legal_o (legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sel_q     <= '0;
      nr_q      <= '0;
      nf_q      <= '0;
      no_q      <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      err_ill_q <= 1'b0;
      err_to_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          err_to_q  <= 1'b0;
          err_ill_q <= !legal;
          if (legal) begin
            sel_q  <= req_pll_i;
            nr_q   <= req_nr_i;
            nf_q   <= req_nf_i;
            no_q   <= req_no_i;
            busy_q <= 1'b1;
            st_q   <= ST_SLOW;
          end
        end
        ST_SLOW: st_q <= ST_RST;
        ST_RST:  st_q <= ST_PROG;
        ST_PROG: st_q <= ST_BW;
        ST_BW:   st_q <= ST_REL;
        ST_REL: begin
          cnt_q <= '0;
          st_q  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lock_i[sel_q]) begin
            st_q <= ST_NORM;
          end else if (cnt_q >= timeout_i) begin
            err_to_q <= 1'b1;
            busy_q   <= 1'b0;
            st_q     <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + TO_W'(1);
          end
        end
        ST_NORM: begin
          busy_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic [BW_W-1:0] bw_val;
  assign bw_val = BW_W'((nf_q >> 1) - NF_W'(1));

  pll_cfg_bank #(
    .NPLL(NPLL), .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_q),
    .mode_clr_i (st_q == ST_SLOW),
    .mode_set_i (st_q == ST_NORM),
    .rst_set_i  (st_q == ST_RST),
    .rst_clr_i  (st_q == ST_REL),
    .prog_i     (st_q == ST_PROG),
    .bw_wr_i    ((st_q == ST_BW) && bwadj_en_i),
    .nr_m1_i    (nr_q - NR_W'(1)),
    .nf_m1_i    (nf_q - NF_W'(1)),
    .no_m1_i    (no_q - NO_W'(1)),
    .bw_i       (bw_val),
    .mode_o     (mode_o),
    .rst_o      (pll_rst_o),
    .nr_o       (cfg_nr_o),
    .nf_o       (cfg_nf_o),
    .no_o       (cfg_no_o),
    .bw_o       (cfg_bw_o)
  );

  pll_rate_calc #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_MHZ(REF_MHZ), .RATE_W(RATE_W)
  ) u_rate (
    .mode_i  (mode_o[rate_sel_i]),
    .nr_m1_i (cfg_nr_o[rate_sel_i*NR_W +: NR_W]),
    .nf_m1_i (cfg_nf_o[rate_sel_i*NF_W +: NF_W]),
    .no_m1_i (cfg_no_o[rate_sel_i*NO_W +: NO_W]),
    .rate_o  (rate_mhz_o)
  );

  assign busy_o        = busy_q;
  assign err_illegal_o = err_ill_q;
  assign err_timeout_o = err_to_q;
endmodule

// File: rtl/pll_reprog_chk.sv
module pll_reprog_chk #(
  parameter int NPLL = 4,
  parameter int NF_W = 13
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NPLL-1:0]      lock_i,
  input logic                 busy_o,
  input logic                 err_illegal_o,
  input logic [NPLL-1:0]      mode_o,
  input logic [NPLL-1:0]      pll_rst_o,
  input logic [NPLL*NF_W-1:0] cfg_nf_o
);
  // R2: reset never overlaps normal mode
  a_r2_reset_only_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_rst_o & mode_o) == '0);

  a_r2_one_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pll_rst_o));

  a_r7_reject_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_illegal_o |-> !busy_o);

  for (genvar k = 0; k < NPLL; k++) begin : g_chk
    a_r3_fields_under_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cfg_nf_o[k*NF_W +: NF_W]) |-> pll_rst_o[k]);

    a_r6_normal_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mode_o[k]) |-> $past(lock_i[k]));

    a_r9_slow_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(mode_o[k]) |-> busy_o);
  end
endmodule

bind pll_reprog_ctrl pll_reprog_chk #(.NPLL(NPLL), .NF_W(NF_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lock_i        (lock_i),
  .busy_o        (busy_o),
  .err_illegal_o (err_illegal_o),
  .mode_o        (mode_o),
  .pll_rst_o     (pll_rst_o),
  .cfg_nf_o      (cfg_nf_o)
);

// File: tb/tb_pll_reprog_ctrl.sv
`timescale 1ns/1ps
module tb_pll_reprog_ctrl;
  localparam int NPLL = 4, NR_W = 6, NF_W = 13, NO_W = 4, BW_W = 12, TO_W = 16;
  localparam int SEL_W = 2, RATE_W = NF_W + 6, LOCK_DLY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bwadj_en = 1'b0, req_valid = 1'b0;
  logic [TO_W-1:0]  timeout = 16'd100;
  logic [SEL_W-1:0] req_pll = '0, rate_sel = '0;
  logic [NR_W-1:0]  req_nr = '0;
  logic [NF_W-1:0]  req_nf = '0;
  logic [NO_W-1:0]  req_no = '0;
  logic [NPLL-1:0]  lock, block = '0;
  logic busy, err_ill, err_to;
  logic [NPLL-1:0] mode, prst;
  logic [NPLL*NR_W-1:0] cfg_nr;
  logic [NPLL*NO_W-1:0] cfg_no;
  logic [NPLL*NF_W-1:0] cfg_nf;
  logic [NPLL*BW_W-1:0] cfg_bw;
  logic [RATE_W-1:0] rate;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  // lock model: rises LOCK_DLY cycles after reset release unless blocked
  int lk_cnt [NPLL];
  always_ff @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < NPLL; k++) begin
      if (!rst_n || prst[k]) lk_cnt[k] <= 0;
      else if (lk_cnt[k] < LOCK_DLY) lk_cnt[k] <= lk_cnt[k] + 1;
    end
  end
  always_comb for (int k = 0; k < NPLL; k++) lock[k] = !block[k] && (lk_cnt[k] == LOCK_DLY);

  pll_reprog_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bwadj_en_i(bwadj_en), .timeout_i(timeout),
    .req_valid_i(req_valid), .req_pll_i(req_pll), .req_nr_i(req_nr),
    .req_nf_i(req_nf), .req_no_i(req_no), .lock_i(lock), .rate_sel_i(rate_sel),
    .busy_o(busy), .err_illegal_o(err_ill), .err_timeout_o(err_to),
    .mode_o(mode), .pll_rst_o(prst), .cfg_nr_o(cfg_nr), .cfg_no_o(cfg_no),
    .cfg_nf_o(cfg_nf), .cfg_bw_o(cfg_bw), .rate_mhz_o(rate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_nr(int k); return int'(cfg_nr[k*NR_W +: NR_W]); endfunction
  function automatic int f_nf(int k); return int'(cfg_nf[k*NF_W +: NF_W]); endfunction
  function automatic int f_no(int k); return int'(cfg_no[k*NO_W +: NO_W]); endfunction
  function automatic int f_bw(int k); return int'(cfg_bw[k*BW_W +: BW_W]); endfunction

  task automatic get_rate(input int k, output int r);
    rate_sel = SEL_W'(k);
    #1 r = int'(rate);
  endtask

  // drive a one-cycle request; returns at the negedge after the accepting edge
  task automatic pulse_req(input int k, input int nr, input int nf, input int no);
    req_pll = SEL_W'(k); req_nr = NR_W'(nr); req_nf = NF_W'(nf); req_no = NO_W'(no);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    int r;
    chk("R1 busy", int'(busy), 0);
    chk("R1 errors", int'({err_ill, err_to}), 0);
    chk("R1 mode", int'(mode), 0);
    chk("R1 reset bits", int'(prst), 0);
    chk("R1 nf fields", int'(cfg_nf != '0), 0);
    get_rate(3, r); chk("R1 R10 rate slow", r, 24);
  endtask

  task automatic t_prog_bw();
    int r;
    bwadj_en = 1'b1;
    pulse_req(0, 1, 50, 2);
    wait_idle();
    chk("R3 nr field", f_nr(0), 0);
    chk("R3 nf field", f_nf(0), 49);
    chk("R3 no field", f_no(0), 1);
    chk("R4 bwadj field", f_bw(0), 24);
    chk("R6 mode normal", int'(mode[0]), 1);
    get_rate(0, r); chk("R10 rate normal", r, 600);
    chk("R11 other pll mode", int'(mode[1]), 0);
    chk("R11 other pll nf", f_nf(1), 0);
  endtask

  task automatic t_order();
    int r;
    bwadj_en = 1'b0;
    pulse_req(0, 3, 100, 1);
    chk("R2 busy at accept", int'(busy), 1);
    chk("R2 mode before slow", int'(mode[0]), 1);
    @(negedge clk);
    chk("R2 mode slow", int'(mode[0]), 0);
    chk("R2 not yet reset", int'(prst[0]), 0);
    @(negedge clk);
    chk("R2 reset set", int'(prst[0]), 1);
    chk("R2 nf not yet written", f_nf(0), 49);
    @(negedge clk);
    chk("R3 nf written in reset", f_nf(0), 99);
    chk("R3 nr written", f_nr(0), 2);
    chk("R3 no written", f_no(0), 0);
    @(negedge clk);
    chk("R2 still in reset at bw stage", int'(prst[0]), 1);
    @(negedge clk);
    chk("R2 reset released", int'(prst[0]), 0);
    chk("R6 mode slow before lock", int'(mode[0]), 0);
    wait_idle();
    chk("R6 mode normal after lock", int'(mode[0]), 1);
    chk("R5 bwadj untouched", f_bw(0), 24);
    get_rate(0, r); chk("R10 rate 800", r, 800);
  endtask

  task automatic t_illegal();
    int pat [4][3] = '{'{1, 50, 3}, '{1, 10, 1}, '{1, 100, 1}, '{0, 50, 2}};
    for (int i = 0; i < 4; i++) begin
      pulse_req(0, pat[i][0], pat[i][1], pat[i][2]);
      chk($sformatf("R7 err flag pattern %0d", i), int'(err_ill), 1);
      chk($sformatf("R7 not busy pattern %0d", i), int'(busy), 0);
      @(negedge clk);
      chk($sformatf("R7 mode kept pattern %0d", i), int'(mode[0]), 1);
      chk($sformatf("R7 nf kept pattern %0d", i), f_nf(0), 99);
      chk($sformatf("R7 reset kept pattern %0d", i), int'(prst), 0);
    end
  endtask

  task automatic t_timeout();
    int r;
    block[2] = 1'b1;
    timeout = 16'd20;
    pulse_req(2, 9, 400, 2);
    chk("R7 legal clears flag", int'(err_ill), 0);
    wait_idle();
    chk("R8 timeout flag", int'(err_to), 1);
    chk("R8 mode slow", int'(mode[2]), 0);
    chk("R8 out of reset", int'(prst[2]), 0);
    chk("R8 fields written", f_nf(2), 399);
    get_rate(2, r); chk("R8 R10 rate slow", r, 24);
    block[2] = 1'b0;
    timeout = 16'd100;
  endtask

  task automatic t_busy_ignore();
    int r;
    pulse_req(1, 9, 400, 2);
    chk("R8 flag cleared by request", int'(err_to), 0);
    @(negedge clk);
    pulse_req(3, 1, 67, 1);
    wait_idle();
    get_rate(1, r); chk("R9 first request done", r, 533);
    chk("R9 second pll mode", int'(mode[3]), 0);
    chk("R9 second pll nf", f_nf(3), 0);
    chk("R11 pll0 nf kept", f_nf(0), 99);
  endtask

  task automatic t_retry();
    int r;
    pulse_req(2, 1, 67, 1);
    wait_idle();
    chk("R6 retry normal", int'(mode[2]), 1);
    get_rate(2, r); chk("R10 rate 1608", r, 1608);
    chk("R8 no timeout", int'(err_to), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog_bw();
    t_order();
    t_illegal();
    t_timeout();
    t_busy_ignore();
    t_retry();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule